// File: doc/BRIEF.md
# PHY Power-Down and Isolate Controller

This block sits between the management register bits of an Ethernet PHY and its transceiver core. It decides when the core is powered, when the core gets a reset pulse, and whether transmit traffic from the MAC side may reach the core. Two sleep paths exist. A register-commanded shutdown always ends with a full core reset. A line-energy sleep saves the core context before power is removed and restores it on wake, with no reset.

An isolate bit blocks the MII transmit inputs so several PHYs can share one MII. Isolation does not touch the management side, which this block never powers down. A wake caused by line energy can raise a latched active-low interrupt, which a management read strobe clears. An external active-low hardware reset counts only if it stays low for a minimum number of clocks. When such a reset is released, the core reset sequence starts again.

Top module: `phy_pwr_ctl`

## Requirements
- R1: While `cfg_isolate` is 1, `core_txd`, `core_tx_en` and `core_tx_er` are all 0 whatever the MII transmit inputs are. They equal the MII inputs only when the sequencer is in normal run and `cfg_isolate` is 0. In every other state they are 0.
- R2: During and right after synchronous `rst`, `core_pwr_en`=1, `core_rst`=1 and `irq_n`=1. After `rst` falls, `core_rst` stays 1 for exactly `RST_CYCLES` cycles.
- R3: When `cfg_gpd` is 1 at a clock edge, `core_pwr_en` is 0 in the next cycle, from any state. This takes priority over energy-detect sleep and over a qualified hardware reset.
- R4: When `cfg_gpd` returns to 0, the next cycle starts a reset window. In that window `core_pwr_en`=1 and `core_rst`=1 for exactly `RST_CYCLES` cycles, then normal run follows.
- R5: In normal run with `cfg_edpd`=1 and `energy_on`=0, the controller spends one cycle with `ctx_save`=1 and power still on. Power then goes off (`core_pwr_en`=0) while the condition holds.
- R6: While asleep, `energy_on`=1 or `cfg_edpd`=0 gives one cycle with `ctx_restore`=1, `core_pwr_en`=1 and `core_rst`=0, followed by normal run.
- R7: A wake caused by `energy_on` while `cfg_wake_ie`=1 drives `irq_n` low in the same cycle as `ctx_restore`. `irq_n` stays low until a cycle with `irq_clr`=1. A new wake in the same cycle as `irq_clr` wins. A wake from clearing `cfg_edpd` raises no interrupt.
- R8: `hw_rst_n` low for at least `HWRST_MIN` consecutive clock edges, then high, restarts the R4 reset window on the edge where it is seen high. If `cfg_gpd`=1 at that edge, power goes off instead. Shorter low pulses have no effect.
- R9: If `energy_on` returns or `cfg_edpd` clears during the `ctx_save` cycle, the controller goes back to normal run. Power never drops and no `ctx_restore` is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_rst_n | input | 1 | External active-low hardware reset request |
| cfg_isolate | input | 1 | Isolate MII transmit inputs |
| cfg_gpd | input | 1 | Register-commanded power-down |
| cfg_edpd | input | 1 | Enable energy-detect sleep |
| cfg_wake_ie | input | 1 | Enable wake interrupt |
| irq_clr | input | 1 | Management read strobe clearing the interrupt |
| energy_on | input | 1 | Line energy present |
| mii_txd | input | 4 | MII transmit data |
| mii_tx_en | input | 1 | MII transmit enable |
| mii_tx_er | input | 1 | MII transmit error |
| core_txd | output | 4 | Gated transmit data to core |
| core_tx_en | output | 1 | Gated transmit enable to core |
| core_tx_er | output | 1 | Gated transmit error to core |
| core_pwr_en | output | 1 | Core power enable |
| core_rst | output | 1 | Core reset |
| ctx_save | output | 1 | Context save strobe before sleep |
| ctx_restore | output | 1 | Context restore strobe on wake |
| irq_n | output | 1 | Active-low wake interrupt |

## Verification
The bench checks that raising power-down and energy sleep together ends in power-down, with no save strobe. It times the reset window after power-down and after a qualified hardware reset to the exact cycle, so an off-by-one counter shows up as a wrong length. Hardware-reset pulses one edge short of and exactly at the minimum show whether the qualifier compares at the right limit. Energy that returns in the save cycle, a wake from clearing the enable, and a wake that lands on a clear strobe catch a controller that drops power needlessly, interrupts on the wrong wake, or lets the clear beat the set.

// File: rtl/phy_pwr_pkg.sv
package phy_pwr_pkg;

    localparam int MII_NIBBLE = 4;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_GPD_OFF  = 3'd1,
        ST_GPD_RST  = 3'd2,
        ST_ED_SAVE  = 3'd3,
        ST_ED_SLEEP = 3'd4,
        ST_ED_WAKE  = 3'd5
    } pwr_state_e;

    typedef struct packed {
        logic [MII_NIBBLE-1:0] d;
        logic                  en;
        logic                  er;
    } tx_bus_t;

    typedef struct packed {
        logic pwr_en;
        logic core_rst;
        logic save;
        logic restore;
    } pwr_ctl_t;

    function automatic pwr_ctl_t ctl_of(input pwr_state_e st);
        pwr_ctl_t c;
        c.pwr_en   = (st != ST_GPD_OFF) && (st != ST_ED_SLEEP);
        c.core_rst = (st == ST_GPD_RST);
        c.save     = (st == ST_ED_SAVE);
        c.restore  = (st == ST_ED_WAKE);
        return c;
    endfunction

    function automatic logic tx_allowed(input pwr_state_e st, input logic iso);
        return (st == ST_RUN) && !iso;
    endfunction

endpackage

// File: rtl/hwrst_qual.sv
module hwrst_qual #(
    parameter int HWRST_MIN = 12500
) (
    input  logic clk,
    input  logic rst,
    input  logic hw_rst_n,
    output logic hw_req
);
    localparam int QW = $clog2(HWRST_MIN + 1);
    localparam logic [QW-1:0] LIMIT = QW'(HWRST_MIN);

    logic [QW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
        end else if (hw_rst_n) begin
            low_cnt <= '0;
        end else if (low_cnt != LIMIT) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign hw_req = hw_rst_n && (low_cnt == LIMIT);
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
    import phy_pwr_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       gpd,
    input  logic       edpd,
    input  logic       energy,
    input  logic       hw_req,
    output pwr_state_e state,
    output logic       wake_by_energy
);
    localparam int CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(RST_CYCLES - 1);

    pwr_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic sleep_wanted;

    assign sleep_wanted = edpd && !energy;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (hw_req) begin
            if (gpd) begin
                st_d = ST_GPD_OFF;
            end else begin
                st_d  = ST_GPD_RST;
                cnt_d = CNT_LOAD;
            end
        end else if (gpd) begin
            st_d = ST_GPD_OFF;
        end else begin
            unique case (st_q)
                ST_RUN: begin
                    if (sleep_wanted) st_d = ST_ED_SAVE;
                end
                ST_GPD_OFF: begin
                    st_d  = ST_GPD_RST;
                    cnt_d = CNT_LOAD;
                end
                ST_GPD_RST: begin
                    if (cnt_q == '0) st_d = ST_RUN;
                    else             cnt_d = cnt_q - 1'b1;
                end
                ST_ED_SAVE: begin
                    st_d = sleep_wanted ? ST_ED_SLEEP : ST_RUN;
                end
                ST_ED_SLEEP: begin
                    if (!sleep_wanted) st_d = ST_ED_WAKE;
                end
                ST_ED_WAKE: begin
                    st_d = ST_RUN;
                end
                default: st_d = ST_GPD_RST;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_GPD_RST;
            cnt_q <= CNT_LOAD;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign state          = st_q;
    assign wake_by_energy = (st_q == ST_ED_SLEEP) && !hw_req && !gpd && energy;
endmodule

// File: rtl/wake_irq.sv
module wake_irq (
    input  logic clk,
    input  logic rst,
    input  logic wake,
    input  logic ie,
    input  logic clr,
    output logic irq_n
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst)               pend_q <= 1'b0;
        else if (wake && ie)   pend_q <= 1'b1;
        else if (clr)          pend_q <= 1'b0;
    end

    assign irq_n = !pend_q;
endmodule

// File: rtl/tx_gate.sv
module tx_gate
    import phy_pwr_pkg::*;
(
    input  logic    allow,
    input  tx_bus_t mac_tx,
    output tx_bus_t core_tx
);
    assign core_tx = allow ? mac_tx : '0;
endmodule

// File: rtl/phy_pwr_ctl.sv
module phy_pwr_ctl
    import phy_pwr_pkg::*;
#(
    parameter int RST_CYCLES = 16,
    parameter int HWRST_MIN  = 12500
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  hw_rst_n,
    input  logic                  cfg_isolate,
    input  logic                  cfg_gpd,
    input  logic                  cfg_edpd,
    input  logic                  cfg_wake_ie,
    input  logic                  irq_clr,
    input  logic                  energy_on,
    input  logic [MII_NIBBLE-1:0] mii_txd,
    input  logic                  mii_tx_en,
    input  logic                  mii_tx_er,
    output logic [MII_NIBBLE-1:0] core_txd,
    output logic                  core_tx_en,
    output logic                  core_tx_er,
    output logic                  core_pwr_en,
    output logic                  core_rst,
    output logic                  ctx_save,
    output logic                  ctx_restore,
    output logic                  irq_n
);
    pwr_state_e state;
    logic       hw_req;
    logic       wake_evt;
    pwr_ctl_t   ctl;
    tx_bus_t    mac_tx, gated_tx;

    hwrst_qual #(.HWRST_MIN(HWRST_MIN)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .hw_rst_n (hw_rst_n),
        .hw_req   (hw_req)
    );

    pwr_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
        .clk            (clk),
        .rst            (rst),
        .gpd            (cfg_gpd),
        .edpd           (cfg_edpd),
        .energy         (energy_on),
        .hw_req         (hw_req),
        .state          (state),
        .wake_by_energy (wake_evt)
    );

    wake_irq u_irq (
        .clk   (clk),
        .rst   (rst),
        .wake  (wake_evt),
        .ie    (cfg_wake_ie),
        .clr   (irq_clr),
        .irq_n (irq_n)
    );

    assign mac_tx.d  = mii_txd;
    assign mac_tx.en = mii_tx_en;
    assign mac_tx.er = mii_tx_er;

    tx_gate u_gate (
        .allow   (tx_allowed(state, cfg_isolate)),
        .mac_tx  (mac_tx),
        .core_tx (gated_tx)
    );

    assign core_txd   = gated_tx.d;
    assign core_tx_en = gated_tx.en;
    assign core_tx_er = gated_tx.er;

    assign ctl         = ctl_of(state);
    assign core_pwr_en = ctl.pwr_en;
    assign core_rst    = ctl.core_rst;
    assign ctx_save    = ctl.save;
    assign ctx_restore = ctl.restore;
endmodule

// File: rtl/pwr_ctl_chk.sv
module pwr_ctl_chk #(
    parameter int RST_CYCLES = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       hw_rst_n,
    input logic       cfg_isolate,
    input logic       cfg_gpd,
    input logic       irq_clr,
    input logic [3:0] core_txd,
    input logic       core_tx_en,
    input logic       core_tx_er,
    input logic       core_pwr_en,
    input logic       core_rst,
    input logic       ctx_save,
    input logic       ctx_restore,
    input logic       irq_n
);
    localparam int CW = $clog2(RST_CYCLES + 2);

    logic [CW-1:0] rst_run;
    logic          hw_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_run <= '0;
            hw_prev <= 1'b1;
        end else begin
            hw_prev <= hw_rst_n;
            if (!core_rst || !hw_prev) rst_run <= '0;
            else                       rst_run <= rst_run + 1'b1;
        end
    end

    AST_ISO_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        cfg_isolate |-> (core_txd == '0 && !core_tx_en && !core_tx_er)); // R1

    AST_GPD_POWERS_OFF: assert property (@(posedge clk) disable iff (rst)
        cfg_gpd |=> !core_pwr_en); // R3

    AST_RST_LEN: assert property (@(posedge clk) disable iff (rst)
        core_rst |-> (rst_run < CW'(RST_CYCLES))); // R4

    AST_RST_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
        ($fell(core_rst) && !$past(cfg_gpd)) |-> core_pwr_en); // R4

    AST_SAVE_BEFORE_OFF: assert property (@(posedge clk) disable iff (rst)
        ($fell(core_pwr_en) && !$past(cfg_gpd)) |-> $past(ctx_save)); // R5

    AST_WAKE_PATH: assert property (@(posedge clk) disable iff (rst)
        $rose(core_pwr_en) |-> (core_rst || ctx_restore)); // R6

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !irq_clr) |=> !irq_n); // R7
endmodule

bind phy_pwr_ctl pwr_ctl_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hw_rst_n    (hw_rst_n),
    .cfg_isolate (cfg_isolate),
    .cfg_gpd     (cfg_gpd),
    .irq_clr     (irq_clr),
    .core_txd    (core_txd),
    .core_tx_en  (core_tx_en),
    .core_tx_er  (core_tx_er),
    .core_pwr_en (core_pwr_en),
    .core_rst    (core_rst),
    .ctx_save    (ctx_save),
    .ctx_restore (ctx_restore),
    .irq_n       (irq_n)
);

// File: tb/sim_phy_pwr_ctl.sv
`timescale 1ns/1ps
module sim_phy_pwr_ctl;
    localparam int RC  = 5;
    localparam int HWM = 16;

    localparam int S_RUN = 0, S_GOFF = 1, S_GRST = 2, S_SAVE = 3, S_SLP = 4, S_WAKE = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, hw_rst_n, cfg_isolate, cfg_gpd, cfg_edpd, cfg_wake_ie, irq_clr, energy_on;
    logic [3:0] mii_txd;
    logic mii_tx_en, mii_tx_er;
    logic [3:0] core_txd;
    logic core_tx_en, core_tx_er, core_pwr_en, core_rst, ctx_save, ctx_restore, irq_n;

    phy_pwr_ctl #(.RST_CYCLES(RC), .HWRST_MIN(HWM)) u0 (
        .clk(clk), .rst(rst), .hw_rst_n(hw_rst_n), .cfg_isolate(cfg_isolate),
        .cfg_gpd(cfg_gpd), .cfg_edpd(cfg_edpd), .cfg_wake_ie(cfg_wake_ie),
        .irq_clr(irq_clr), .energy_on(energy_on), .mii_txd(mii_txd),
        .mii_tx_en(mii_tx_en), .mii_tx_er(mii_tx_er), .core_txd(core_txd),
        .core_tx_en(core_tx_en), .core_tx_er(core_tx_er), .core_pwr_en(core_pwr_en),
        .core_rst(core_rst), .ctx_save(ctx_save), .ctx_restore(ctx_restore), .irq_n(irq_n)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int m_st, m_cnt, m_hwc;
    bit m_irq;
    bit m_valid = 0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_tx(input int d);
        return (m_st == S_RUN && !cfg_isolate) ? d : 0;
    endfunction

    task automatic compare_all();
        if (!m_valid) return;
        chk("R1 core_txd",   core_txd,   exp_tx(mii_txd));
        chk("R1 core_tx_en", core_tx_en, exp_tx(mii_tx_en));
        chk("R1 core_tx_er", core_tx_er, exp_tx(mii_tx_er));
        chk("R3 core_pwr_en", core_pwr_en, (m_st != S_GOFF && m_st != S_SLP));
        chk("R4 core_rst",   core_rst,   (m_st == S_GRST));
        chk("R5 ctx_save",   ctx_save,   (m_st == S_SAVE));
        chk("R6 ctx_restore", ctx_restore, (m_st == S_WAKE));
        chk("R7 irq_n",      irq_n,      !m_irq);
    endtask

    task automatic model_update();
        bit hwreq, wake, want;
        hwreq = hw_rst_n && (m_hwc == HWM);
        want  = cfg_edpd && !energy_on;
        if (rst) begin
            m_st = S_GRST; m_cnt = RC - 1; m_hwc = 0; m_irq = 0; m_valid = 1;
            return;
        end
        wake = (m_st == S_SLP) && !hwreq && !cfg_gpd && energy_on;
        if (wake && cfg_wake_ie) m_irq = 1;
        else if (irq_clr)        m_irq = 0;
        if (hw_rst_n) m_hwc = 0;
        else if (m_hwc < HWM) m_hwc = m_hwc + 1;
        if (hwreq) begin
            if (cfg_gpd) m_st = S_GOFF;
            else begin m_st = S_GRST; m_cnt = RC - 1; end
        end else if (cfg_gpd) begin
            m_st = S_GOFF;
        end else if (m_st == S_RUN) begin
            if (want) m_st = S_SAVE;
        end else if (m_st == S_GOFF) begin
            m_st = S_GRST; m_cnt = RC - 1;
        end else if (m_st == S_GRST) begin
            if (m_cnt == 0) m_st = S_RUN; else m_cnt = m_cnt - 1;
        end else if (m_st == S_SAVE) begin
            m_st = want ? S_SLP : S_RUN;
        end else if (m_st == S_SLP) begin
            if (!want) m_st = S_WAKE;
        end else begin
            m_st = S_RUN;
        end
    endtask

    task automatic step();
        #1 compare_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic drain_reset(input string tag);
        int n = 0;
        while (core_rst && n < 100) begin n++; step(); end
        chk(tag, n, RC);
    endtask

    int hw_hold = 0;

    initial begin
        void'($urandom(32'd4711));
        rst = 1; hw_rst_n = 1; cfg_isolate = 0; cfg_gpd = 0; cfg_edpd = 0;
        cfg_wake_ie = 0; irq_clr = 0; energy_on = 1;
        mii_txd = 4'hA; mii_tx_en = 1; mii_tx_er = 0;
        @(negedge clk);
        repeat (3) step();
        // R2 reset state
        chk("R2 core_rst in reset", core_rst, 1);
        chk("R2 core_pwr_en in reset", core_pwr_en, 1);
        chk("R2 irq_n in reset", irq_n, 1);
        rst = 0;
        drain_reset("R2 reset window length");

        // R1 isolate
        cfg_isolate = 1; mii_txd = 4'hF; mii_tx_en = 1; mii_tx_er = 1;
        #1 chk("R1 isolated tx_en", core_tx_en, 0);
        chk("R1 isolated txd", core_txd, 0);
        step();
        cfg_isolate = 0;
        #1 chk("R1 pass txd", core_txd, 4'hF);
        step();

        // R8 short pulse ignored, qualified pulse accepted
        hw_rst_n = 0;
        repeat (HWM - 1) step();
        hw_rst_n = 1; step();
        chk("R8 short low ignored", core_rst, 0);
        hw_rst_n = 0;
        repeat (HWM) step();
        hw_rst_n = 1; step();
        chk("R8 qualified low resets", core_rst, 1);
        drain_reset("R8 reset window length");

        // R9 abort during save
        cfg_edpd = 1; energy_on = 0; step();
        chk("R5 save strobe", ctx_save, 1);
        chk("R5 power on during save", core_pwr_en, 1);
        energy_on = 1; step();
        chk("R9 back to run power", core_pwr_en, 1);
        chk("R9 no restore", ctx_restore, 0);
        chk("R9 no save", ctx_save, 0);

        // R5..R7 energy sleep and wake with interrupt
        cfg_wake_ie = 1; energy_on = 0; mii_tx_en = 1;
        step(); step();
        chk("R5 asleep power off", core_pwr_en, 0);
        chk("R5 asleep tx_en", core_tx_en, 0);
        energy_on = 1; step();
        chk("R6 restore strobe", ctx_restore, 1);
        chk("R6 no reset on wake", core_rst, 0);
        chk("R7 irq on energy wake", irq_n, 0);
        step();
        chk("R7 irq held", irq_n, 0);
        irq_clr = 1; step(); irq_clr = 0;
        chk("R7 irq cleared", irq_n, 1);

        // R7 wake by clearing enable: no interrupt
        energy_on = 0; step(); step();
        cfg_edpd = 0; step();
        chk("R6 restore on disable", ctx_restore, 1);
        chk("R7 no irq on disable wake", irq_n, 1);
        step();
        energy_on = 1;

        // R3 priority over energy sleep, R4 reset after power-down
        cfg_edpd = 1; energy_on = 0; cfg_gpd = 1; step();
        chk("R3 gpd wins power", core_pwr_en, 0);
        chk("R3 gpd wins no save", ctx_save, 0);
        cfg_edpd = 0; energy_on = 1; step();
        cfg_gpd = 0; step();
        chk("R4 reset after gpd", core_rst, 1);
        chk("R4 powered during reset", core_pwr_en, 1);
        drain_reset("R4 reset window length");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if (energy_on) begin if ($urandom_range(39) == 0) energy_on = 0; end
            else if ($urandom_range(7) == 0) energy_on = 1;
            if ($urandom_range(99) == 0)  cfg_edpd = !cfg_edpd;
            if ($urandom_range(199) == 0) cfg_gpd = !cfg_gpd;
            if ($urandom_range(29) == 0)  cfg_isolate = !cfg_isolate;
            if ($urandom_range(49) == 0)  cfg_wake_ie = !cfg_wake_ie;
            irq_clr = ($urandom_range(19) == 0);
            if (hw_hold > 0) begin hw_hold--; hw_rst_n = (hw_hold == 0); end
            else if ($urandom_range(299) == 0) begin
                hw_hold = $urandom_range(HWM + 6, HWM - 6); hw_rst_n = 0;
            end
            mii_txd = 4'($urandom); mii_tx_en = 1'($urandom); mii_tx_er = 1'($urandom);
            step();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule